// File: doc/BRIEF.md
# Burst-of-Four Quad-Rate SRAM Command Front-End

This block models the device side of a quad-data-rate static RAM that moves four words per command. Read and write commands have separate select inputs and separate address buses, and both are sampled on each rising clock edge. Each transfer is carried as two half-cycle words per clock, one for the rising half and one for the falling half. A write collects four words, one on each half of the two cycles after it is accepted, and then stores them in four consecutive array locations. A read fetches four consecutive locations and sends them out after a latency that is set in half-cycles.

A burst takes four half-cycle beats, which is two clock edges. For that reason a request that arrives on the edge right after an accepted request of the same type is dropped without effect. The block raises a one-cycle debug flag when that happens. Reads and writes are independent, so one of each can be accepted on the same edge.

Top module: `qb4_sram_front`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `q_rise_vld`, `q_fall_vld` and `drop_flag` are 0.
- R2: A read is accepted when `rd_sel_n` is 0 at a rising edge, and `rd_addr` is captured at that edge.
- R3: For a read accepted at edge r, word k (k = 0..3) is the array location (address + k) modulo the array depth. It appears on half-cycle 2r + RD_LAT_HALF + k. Half-cycle 2e is `q_rise` and half-cycle 2e+1 is `q_fall`, both registered at edge e with their valid bit set. Outside a burst the valid bits are 0.
- R4: A read request at the edge directly after an accepted read produces no output words.
- R5: A write is accepted when `wr_sel_n` is 0 at edge e, and `wr_addr` is captured at that edge. Word 0 and word 1 are taken from `wd_rise` and `wd_fall` at edge e+1. Word 2 and word 3 are taken from `wd_rise` and `wd_fall` at edge e+2. Word k goes to location (address + k) modulo depth.
- R6: A write request at the edge directly after an accepted write changes no location.
- R7: `bw_rise_n` / `bw_fall_n` bit j is active low. It enables bits [9j+8:9j] of the rise or fall word sampled at the same edge. A disabled byte keeps its old content.
- R8: A write accepted at edge e updates the array at edge e+2. A read accepted at or before edge e+2 returns the old contents. A read accepted later returns the new contents.
- R9: `drop_flag` is 1 for exactly the cycle after an edge at which a read or a write request was dropped, and 0 otherwise.
- R10: A read and a write may be accepted at the same edge. A request two edges after an accepted one of the same type is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Read request, active low |
| rd_addr | input | ADDR_W | Read start address |
| wr_sel_n | input | 1 | Write request, active low |
| wr_addr | input | ADDR_W | Write start address |
| wd_rise | input | 9*NBYTES | Write word for the rising half |
| wd_fall | input | 9*NBYTES | Write word for the falling half |
| bw_rise_n | input | NBYTES | Byte enables for `wd_rise`, active low |
| bw_fall_n | input | NBYTES | Byte enables for `wd_fall`, active low |
| q_rise | output | 9*NBYTES | Read word for the rising half |
| q_fall | output | 9*NBYTES | Read word for the falling half |
| q_rise_vld | output | 1 | `q_rise` carries a read word |
| q_fall_vld | output | 1 | `q_fall` carries a read word |
| drop_flag | output | 1 | A request was dropped at the previous edge |

## Verification
The bench targets the following corner cases:
- **Back-to-back reads and writes.** A design without the drop rule would emit a second, overlapping burst or corrupt the locations at the dropped write address.
- **A read at the commit edge versus a read after it.** A commit that came too early, or a read that did not return the old word, would show new data too soon.
- **Unaligned starts and the wrap past the top address.** These catch rotation or bank-row errors that shuffle or misplace words.
- **Partial byte enables on separate beats.** These show whether masks are tied to the wrong beat or the wrong byte lane.
- **The half-cycle position of every word with the odd default latency.** An off-by-one in the delay line would move every word by one lane.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  localparam int BEATS   = 4;
  localparam int BYTE_W  = 9;
  typedef logic [1:0] lane_t;
endpackage

// File: rtl/qb4_req_gate.sv
module qb4_req_gate (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  output logic take,
  output logic dropped
);
  logic taken_q;

  always_comb begin
    take    = !sel_n && !taken_q;
    dropped = !sel_n && taken_q;
  end

  always_ff @(posedge clk) begin
    if (rst) taken_q <= 1'b0;
    else     taken_q <= take;
  end
endmodule

// File: rtl/qb4_wr_collect.sv
module qb4_wr_collect
  import qb4_pkg::*;
#(
  parameter int NBYTES = 2,
  parameter int ADDR_W = 8,
  localparam int DW = NBYTES * BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wd_rise,
  input  logic [DW-1:0]          wd_fall,
  input  logic [NBYTES-1:0]      bw_rise_n,
  input  logic [NBYTES-1:0]      bw_fall_n,
  output logic                   commit,
  output logic [ADDR_W-1:0]      commit_addr,
  output logic [BEATS*DW-1:0]    words,
  output logic [BEATS*NBYTES-1:0] byte_en
);
  logic              ph1, ph2;
  logic [ADDR_W-1:0] a1, a2;
  logic [DW-1:0]     b0, b1;
  logic [NBYTES-1:0] m0, m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph1 <= 1'b0;
      ph2 <= 1'b0;
    end else begin
      ph1 <= take;
      ph2 <= ph1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) a1 <= addr;
    if (ph1) begin
      a2 <= a1;
      b0 <= wd_rise;
      b1 <= wd_fall;
      m0 <= ~bw_rise_n;
      m1 <= ~bw_fall_n;
    end
  end

  always_comb begin
    commit      = ph2;
    commit_addr = a2;
    words       = {wd_fall, wd_rise, b1, b0};
    byte_en     = {~bw_fall_n, ~bw_rise_n, m1, m0};
  end

  AST_COMMIT_SPACING: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit); // R6
endmodule

// File: rtl/qb4_bank_array.sv
module qb4_bank_array
  import qb4_pkg::*;
#(
  parameter int NBYTES = 2,
  parameter int ADDR_W = 8,
  localparam int DW    = NBYTES * BYTE_W,
  localparam int ROW_W = ADDR_W - 2,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wa,
  input  logic [BEATS*DW-1:0]     wwords,
  input  logic [BEATS*NBYTES-1:0] wbe,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       ra,
  output logic [BEATS*DW-1:0]     bank_q
);
  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    localparam lane_t BI = lane_t'(b);
    logic [DW-1:0]     mem [ROWS];
    lane_t             wk, rk;
    logic [ADDR_W-1:0] wadr, radr;
    logic [ROW_W-1:0]  wrow, rrow;

    always_comb begin
      wk   = BI - wa[1:0];
      rk   = BI - ra[1:0];
      wadr = wa + {{(ADDR_W-2){1'b0}}, wk};
      radr = ra + {{(ADDR_W-2){1'b0}}, rk};
      wrow = ROW_W'(wadr >> 2);
      rrow = ROW_W'(radr >> 2);
    end

    always_ff @(posedge clk) begin
      if (we) begin
        for (int j = 0; j < NBYTES; j++) begin
          if (wbe[int'(wk)*NBYTES + j])
            mem[wrow][j*BYTE_W +: BYTE_W] <= wwords[int'(wk)*DW + j*BYTE_W +: BYTE_W];
        end
      end
      if (re) bank_q[b*DW +: DW] <= mem[rrow];
    end
  end
endmodule

// File: rtl/qb4_rd_seq.sv
module qb4_rd_seq
  import qb4_pkg::*;
#(
  parameter int NBYTES      = 2,
  parameter int RD_LAT_HALF = 5,
  localparam int DW   = NBYTES * BYTE_W,
  localparam int STG  = RD_LAT_HALF / 2,
  localparam bit ODD  = (RD_LAT_HALF % 2) == 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  lane_t               rot,
  input  logic [BEATS*DW-1:0] bank_q,
  output logic [DW-1:0]       q_rise,
  output logic [DW-1:0]       q_fall,
  output logic                q_rise_vld,
  output logic                q_fall_vld
);
  logic                v0;
  lane_t               rot0;
  logic [BEATS*DW-1:0] w0;
  logic                go;
  logic [BEATS*DW-1:0] gw;

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else     v0 <= take;
    if (take) rot0 <= rot;
  end

  always_comb begin
    for (int k = 0; k < BEATS; k++)
      w0[k*DW +: DW] = bank_q[int'(lane_t'(rot0 + lane_t'(k)))*DW +: DW];
  end

  if (STG == 1) begin : g_nodly
    always_comb begin
      go = v0;
      gw = w0;
    end
  end else begin : g_dly
    localparam int N = STG - 1;
    logic [BEATS*DW-1:0] dw [N];
    logic [N-1:0]        dv;

    always_ff @(posedge clk) begin
      dw[0] <= w0;
      for (int i = 1; i < N; i++) dw[i] <= dw[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst) dv <= '0;
      else begin
        dv[0] <= v0;
        for (int i = 1; i < N; i++) dv[i] <= dv[i-1];
      end
    end

    always_comb begin
      go = dv[N-1];
      gw = dw[N-1];
    end
  end

  if (!ODD) begin : g_even
    logic          pend;
    logic [DW-1:0] t2, t3;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend <= 1'b0; q_rise_vld <= 1'b0; q_fall_vld <= 1'b0;
        q_rise <= '0; q_fall <= '0;
      end else begin
        q_rise_vld <= 1'b0;
        q_fall_vld <= 1'b0;
        pend       <= 1'b0;
        if (pend) begin
          q_rise <= t2; q_fall <= t3;
          q_rise_vld <= 1'b1; q_fall_vld <= 1'b1;
        end
        if (go) begin
          q_rise <= gw[0 +: DW]; q_fall <= gw[DW +: DW];
          q_rise_vld <= 1'b1; q_fall_vld <= 1'b1;
          t2 <= gw[2*DW +: DW]; t3 <= gw[3*DW +: DW];
          pend <= 1'b1;
        end
      end
    end
  end else begin : g_odd
    logic          pend1, pend2;
    logic [DW-1:0] t1, t2, t3;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend1 <= 1'b0; pend2 <= 1'b0; q_rise_vld <= 1'b0; q_fall_vld <= 1'b0;
        q_rise <= '0; q_fall <= '0;
      end else begin
        q_rise_vld <= 1'b0;
        q_fall_vld <= 1'b0;
        pend1      <= 1'b0;
        pend2      <= pend1;
        if (pend2) begin
          q_rise <= t3; q_rise_vld <= 1'b1;
        end
        if (pend1) begin
          q_rise <= t1; q_fall <= t2;
          q_rise_vld <= 1'b1; q_fall_vld <= 1'b1;
        end
        if (go) begin
          q_fall <= gw[0 +: DW]; q_fall_vld <= 1'b1;
          t1 <= gw[DW +: DW]; t2 <= gw[2*DW +: DW]; t3 <= gw[3*DW +: DW];
          pend1 <= 1'b1;
        end
      end
    end
  end

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (rst)
    go |=> !go); // R4
endmodule

// File: rtl/qb4_sram_front.sv
module qb4_sram_front
  import qb4_pkg::*;
#(
  parameter int NBYTES      = 2,
  parameter int ADDR_W      = 8,
  parameter int RD_LAT_HALF = 5,
  localparam int DW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wd_rise,
  input  logic [DW-1:0]     wd_fall,
  input  logic [NBYTES-1:0] bw_rise_n,
  input  logic [NBYTES-1:0] bw_fall_n,
  output logic [DW-1:0]     q_rise,
  output logic [DW-1:0]     q_fall,
  output logic              q_rise_vld,
  output logic              q_fall_vld,
  output logic              drop_flag
);
  logic                    rd_take, rd_drop, wr_take, wr_drop;
  logic                    commit;
  logic [ADDR_W-1:0]       commit_addr;
  logic [BEATS*DW-1:0]     cwords, bank_q;
  logic [BEATS*NBYTES-1:0] cbe;

  qb4_req_gate u_rd_gate (.clk(clk), .rst(rst), .sel_n(rd_sel_n), .take(rd_take), .dropped(rd_drop));
  qb4_req_gate u_wr_gate (.clk(clk), .rst(rst), .sel_n(wr_sel_n), .take(wr_take), .dropped(wr_drop));

  qb4_wr_collect #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_wcol (
    .clk(clk), .rst(rst), .take(wr_take), .addr(wr_addr),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .bw_rise_n(bw_rise_n), .bw_fall_n(bw_fall_n),
    .commit(commit), .commit_addr(commit_addr), .words(cwords), .byte_en(cbe));

  qb4_bank_array #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_banks (
    .clk(clk), .we(commit), .wa(commit_addr), .wwords(cwords), .wbe(cbe),
    .re(rd_take), .ra(rd_addr), .bank_q(bank_q));

  qb4_rd_seq #(.NBYTES(NBYTES), .RD_LAT_HALF(RD_LAT_HALF)) u_rseq (
    .clk(clk), .rst(rst), .take(rd_take), .rot(rd_addr[1:0]), .bank_q(bank_q),
    .q_rise(q_rise), .q_fall(q_fall), .q_rise_vld(q_rise_vld), .q_fall_vld(q_fall_vld));

  always_ff @(posedge clk) begin
    if (rst) drop_flag <= 1'b0;
    else     drop_flag <= rd_drop || wr_drop;
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!q_rise_vld && !q_fall_vld && !drop_flag)); // R1
  AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    drop_flag |-> $past(!rd_sel_n || !wr_sel_n)); // R9
endmodule

// File: tb/tb_qb4_sram_front.sv
module tb_qb4_sram_front;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 5;
  localparam int AW  = 8;
  localparam int NB  = 2;
  localparam int DW  = 18;

  typedef struct packed {
    logic          rdn;
    logic [AW-1:0] ra;
    logic          wrn;
    logic [AW-1:0] wa;
    logic [DW-1:0] wr;
    logic [DW-1:0] wf;
    logic [NB-1:0] brn;
    logic [NB-1:0] bfn;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'd10, 1'b0, 8'd10, 18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b0, 8'd20, 1'b1, 8'd0,  18'h0AAAA, 18'h15555, 2'b00, 2'b00},
    '{1'b0, 8'd10, 1'b0, 8'd30, 18'h03C3C, 18'h3C3C3, 2'b00, 2'b00},
    '{1'b1, 8'd0,  1'b0, 8'd50, 18'h12345, 18'h2ABCD, 2'b01, 2'b10},
    '{1'b0, 8'd10, 1'b1, 8'd0,  18'h00FF0, 18'h3F00F, 2'b11, 2'b00},
    '{1'b1, 8'd0,  1'b1, 8'd0,  18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00},
    '{1'b0, 8'd30, 1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b1, 8'd0,  1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b0, 8'd50, 1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b0, 8'd48, 1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b0, 8'd48, 1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b1, 8'd0,  1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b1, 8'd0,  1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11},
    '{1'b1, 8'd0,  1'b1, 8'd0,  18'h00000, 18'h00000, 2'b11, 2'b11}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wd_rise = '0, wd_fall = '0;
  logic [NB-1:0] bw_rise_n = '1, bw_fall_n = '1;
  logic [DW-1:0] q_rise, q_fall;
  logic          q_rise_vld, q_fall_vld, drop_flag;

  qb4_sram_front #(.NBYTES(NB), .ADDR_W(AW), .RD_LAT_HALF(LAT)) dut (
    .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .bw_rise_n(bw_rise_n), .bw_fall_n(bw_fall_n), .q_rise(q_rise), .q_fall(q_fall),
    .q_rise_vld(q_rise_vld), .q_fall_vld(q_fall_vld), .drop_flag(drop_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_fail = 0, ecnt = 0;
  string cur_tag = "R1";

  logic [DW-1:0] mm [256];
  logic [DW-1:0] xr [16], xf [16];
  bit            xvr [16], xvf [16];
  bit            m_racc = 0, m_wacc = 0, m_drop = 0;
  bit            p1 = 0, p2 = 0;
  logic [AW-1:0] p1a, p2a;
  logic [DW-1:0] p2b0, p2b1;
  logic [NB-1:0] p2m0, p2m1;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int x);
    logic [7:0] b = 8'(x);
    return {b ^ 8'h5A, 2'b01, b};
  endfunction

  task automatic put(input int a, input logic [DW-1:0] d, input logic [NB-1:0] en);
    for (int j = 0; j < NB; j++)
      if (en[j]) mm[a & 255][j*9 +: 9] = d[j*9 +: 9];
  endtask

  task automatic step(input logic rdn, input logic [AW-1:0] ra, input logic wrn, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wr, input logic [DW-1:0] wf,
                      input logic [NB-1:0] brn, input logic [NB-1:0] bfn);
    bit racc, wacc, rdrop, wdrop;
    int idx;
    @(negedge clk);
    rd_sel_n = rdn; rd_addr = ra; wr_sel_n = wrn; wr_addr = wa;
    wd_rise = wr; wd_fall = wf; bw_rise_n = brn; bw_fall_n = bfn;
    @(posedge clk);
    ecnt++;
    racc  = !rdn && !m_racc;  rdrop = !rdn && m_racc;
    wacc  = !wrn && !m_wacc;  wdrop = !wrn && m_wacc;
    if (racc) begin
      for (int k = 0; k < 4; k++) begin
        int h = 2*ecnt + LAT + k;
        int e = (h / 2) % 16;
        if (h % 2 == 0) begin xr[e] = mm[(int'(ra) + k) & 255]; xvr[e] = 1; end
        else            begin xf[e] = mm[(int'(ra) + k) & 255]; xvf[e] = 1; end
      end
    end
    if (p2) begin
      put(int'(p2a),     p2b0, p2m0);
      put(int'(p2a) + 1, p2b1, p2m1);
      put(int'(p2a) + 2, wr,   ~brn);
      put(int'(p2a) + 3, wf,   ~bfn);
    end
    p2 = p1;
    if (p1) begin p2a = p1a; p2b0 = wr; p2b1 = wf; p2m0 = ~brn; p2m1 = ~bfn; end
    p1 = wacc;
    if (wacc) p1a = wa;
    m_racc = racc; m_wacc = wacc; m_drop = rdrop || wdrop;
    #1;
    idx = ecnt % 16;
    chk(q_rise_vld == xvr[idx], "R3 q_rise_vld", 32'(q_rise_vld), 32'(xvr[idx]));
    chk(q_fall_vld == xvf[idx], "R3 q_fall_vld", 32'(q_fall_vld), 32'(xvf[idx]));
    if (xvr[idx]) chk(q_rise == xr[idx], "R3 q_rise", 32'(q_rise), 32'(xr[idx]));
    if (xvf[idx]) chk(q_fall == xf[idx], "R3 q_fall", 32'(q_fall), 32'(xf[idx]));
    chk(drop_flag == m_drop, "R9 drop_flag", 32'(drop_flag), 32'(m_drop));
    xvr[idx] = 0; xvf[idx] = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, '0, 1'b1, '0, '0, '0, '1, '1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_tag = "R1 reset";
    chk(q_rise_vld == 1'b0, "q_rise_vld", 32'(q_rise_vld), 0);
    chk(q_fall_vld == 1'b0, "q_fall_vld", 32'(q_fall_vld), 0);
    chk(drop_flag == 1'b0, "drop_flag", 32'(drop_flag), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(!q_rise_vld && !q_fall_vld && !drop_flag, "first cycle quiet", 32'({q_rise_vld, q_fall_vld, drop_flag}), 0);

    cur_tag = "R5 R10 fill";
    for (int i = 0; i < 64; i++) begin
      step(1'b1, '0, 1'b0, AW'(4*i), pat(4*i-2), pat(4*i-1), (i == 0) ? 2'b11 : 2'b00, (i == 0) ? 2'b11 : 2'b00);
      step(1'b1, '0, 1'b1, '0, pat(4*i), pat(4*i+1), 2'b00, 2'b00);
    end
    step(1'b1, '0, 1'b1, '0, pat(254), pat(255), 2'b00, 2'b00);
    idle(2);

    cur_tag = "R2 R3 R10 read sweep";
    for (int i = 0; i < 40; i++) begin
      step(1'b0, AW'(i*6 + 1), 1'b1, '0, '0, '0, '1, '1);
      idle(1);
    end
    idle(4);

    cur_tag = "R4 R6 R7 R8 R9 R10 corner table";
    for (int v = 0; v < NV; v++)
      step(TBL[v].rdn, TBL[v].ra, TBL[v].wrn, TBL[v].wa, TBL[v].wr, TBL[v].wf, TBL[v].brn, TBL[v].bfn);
    idle(4);

    cur_tag = "R3 wrap at top address";
    step(1'b0, 8'd254, 1'b1, '0, '0, '0, '1, '1);
    idle(5);

    cur_tag = "R4 R9 read drop";
    step(1'b0, 8'd7, 1'b1, '0, '0, '0, '1, '1);
    step(1'b0, 8'd99, 1'b1, '0, '0, '0, '1, '1);
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule